// File: doc/BRIEF.md
# CPU Status and Reset-Cause Register

This block is the 8-bit status/control register of a small microcontroller core. It sits at one fixed register-file address and can be reached in any bank. It records the cause of the most recent reset (power-on, brown-out, external pin, watchdog). It also records whether the core has gone to sleep, whether the watchdog has expired, and whether the 4-bit hardware return stack has overflowed. One software-owned bit disables all interrupts and drives the `glint_dis_o` output.

Bit layout, from bit 7 down to bit 0: two unimplemented bits, stack-available, global interrupt disable, timeout flag, power-down flag, power-on flag, brown-out flag. Only the interrupt disable, power-on and brown-out bits accept software writes. The other bits belong to hardware. The power-on and brown-out flags are cleared by their own reset and are set again only by software. A cleared stack-available flag stays clear until a device reset.

A watchdog timeout has two meanings, chosen by the power-down flag. While the core sleeps (flag 0) the timeout is a wake-up. Otherwise it is a device reset.

Top module: `cpu_status_reg`

## Requirements
- R1: After power-on reset (`rst_n` low) a read of address 06h returns 8'h3C (stack-available, interrupt disable, timeout and power-down at 1; power-on and brown-out flags at 0), and `glint_dis_o` is 1.
- R2: Bits 7 and 6 always read 0. A read of any address other than 06h returns 8'h00. The read port is combinational on the stored state.
- R3: A stack push (`stk_push_i`) with `stk_ptr_i` equal to Eh or Fh, meaning the pointer reaches Fh or wraps to 0h, clears bit 5. Bit 5 stays 0 through writes and through sleep, CLRWDT and watchdog wake-ups, and returns to 1 only on a device reset (brown-out, external pin, or watchdog reset).
- R4: Bit 4 is written from bit 4 of a write to 06h. It is forced to 1 by every device reset, and `glint_dis_o` always equals it.
- R5: Bit 3 is cleared by `wdt_timeout_i`. It is set by `clrwdt_i` and by a brown-out reset. If CLRWDT and a timeout arrive together, the timeout wins.
- R6: Bit 2 is cleared by `sleep_i`. It is set by `clrwdt_i` and by a brown-out reset. If both instructions arrive together, sleep wins.
- R7: Bit 1 is written from bit 1 of a write to 06h. No brown-out, external or watchdog reset changes it.
- R8: Bit 0 is written from bit 0 of a write to 06h. A brown-out reset clears it. No external or watchdog reset changes it.
- R9: A write to 06h never changes bits 5, 3 and 2.
- R10: When a hardware event and a write touch the same bit in the same cycle, the hardware value is stored.
- R11: A watchdog timeout while bit 2 is 0 (asleep) is a wake-up that only clears bit 3. While bit 2 is 1 it is a watchdog reset: bit 3 clears, bits 5 and 4 go to 1, and bits 2, 1 and 0 keep their values.
- R12: A write or event takes effect at the next rising clock edge. Before that edge, a read returns the old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Power-on reset, asynchronous, active low |
| wr_en_i | input | 1 | Register-file write strobe |
| wr_addr_i | input | 8 | Write address |
| wr_data_i | input | 8 | Write data |
| rd_addr_i | input | 8 | Read address |
| rd_data_o | output | 8 | Read data |
| bor_rst_i | input | 1 | Brown-out reset event |
| ext_rst_i | input | 1 | External reset-pin event |
| wdt_timeout_i | input | 1 | Watchdog expiry event |
| clrwdt_i | input | 1 | CLRWDT instruction executed |
| sleep_i | input | 1 | SLEEP instruction executed |
| stk_push_i | input | 1 | Stack-pointer increment |
| stk_ptr_i | input | 4 | Stack pointer value before the increment |
| glint_dis_o | output | 1 | Global interrupt disable |

## Verification
Every write and event updates one register stage, so its result is due on the read port in the cycle after the rising edge that samples it. The read path adds no delay. The bench drives inputs at the falling edge and advances its expected state at that same edge. It then checks the read data and `glint_dis_o` one nanosecond after the next rising edge. For R12 it also reads once more in the cycle where the write is still pending, and expects the old value then.

// File: rtl/cpustat_pkg.sv
package cpustat_pkg;

    localparam int DATA_W   = 8;
    localparam int ADDR_W   = 8;
    localparam int SP_W     = 4;
    localparam int STAT_W   = 6;

    localparam int B_STKAV  = 5;
    localparam int B_GLINTD = 4;
    localparam int B_TO     = 3;
    localparam int B_PD     = 2;
    localparam int B_POR    = 1;
    localparam int B_BOR    = 0;

    localparam logic [ADDR_W-1:0] CSR_ADDR = 8'h06;

    typedef struct packed {
        logic stkav;
        logic glintd;
        logic to;
        logic pd;
        logic por;
        logic bor;
    } stat_t;

    localparam stat_t STAT_POR = '{stkav: 1'b1, glintd: 1'b1, to: 1'b1,
                                   pd: 1'b1, por: 1'b0, bor: 1'b0};

endpackage

// File: rtl/cpustat_stk_mon.sv
module cpustat_stk_mon #(
    parameter int SP_W = 4
) (
    input  logic            stk_push_i,
    input  logic [SP_W-1:0] stk_ptr_i,
    output logic            ovf_o
);
    localparam logic [SP_W-1:0] TOP      = {SP_W{1'b1}};
    localparam logic [SP_W-1:0] BELOW_TOP = TOP - 1'b1;

    // Pointer reaches the top entry or wraps past it.
    always_comb begin
        ovf_o = stk_push_i && ((stk_ptr_i == BELOW_TOP) || (stk_ptr_i == TOP));
    end
endmodule

// File: rtl/cpustat_rd_mux.sv
module cpustat_rd_mux
    import cpustat_pkg::*;
#(
    parameter int                ADDR_W_P = 8,
    parameter int                DATA_W_P = 8,
    parameter logic [ADDR_W_P-1:0] HIT_ADDR = 8'h06
) (
    input  logic [ADDR_W_P-1:0] rd_addr_i,
    input  stat_t               stat_i,
    output logic [DATA_W_P-1:0] rd_data_o
);
    localparam int PAD_W = DATA_W_P - STAT_W;

    logic [DATA_W_P-1:0] image;

    generate
        if (PAD_W > 0) begin : g_pad
            assign image = {{PAD_W{1'b0}}, stat_i};
        end else begin : g_nopad
            assign image = stat_i[DATA_W_P-1:0];
        end
    endgenerate

    always_comb begin
        rd_data_o = (rd_addr_i == HIT_ADDR) ? image : '0;
    end
endmodule

// File: rtl/cpu_status_reg.sv
module cpu_status_reg
    import cpustat_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic [ADDR_W-1:0] rd_addr_i,
    output logic [DATA_W-1:0] rd_data_o,
    input  logic              bor_rst_i,
    input  logic              ext_rst_i,
    input  logic              wdt_timeout_i,
    input  logic              clrwdt_i,
    input  logic              sleep_i,
    input  logic              stk_push_i,
    input  logic [SP_W-1:0]   stk_ptr_i,
    output logic              glint_dis_o
);
    stat_t state_d, state_q;
    logic  wr_hit;
    logic  stk_ovf;
    logic  wdt_reset;
    logic  dev_reset;

    cpustat_stk_mon #(.SP_W(SP_W)) u_stk (
        .stk_push_i (stk_push_i),
        .stk_ptr_i  (stk_ptr_i),
        .ovf_o      (stk_ovf)
    );

    cpustat_rd_mux #(
        .ADDR_W_P (ADDR_W),
        .DATA_W_P (DATA_W),
        .HIT_ADDR (CSR_ADDR)
    ) u_rd (
        .rd_addr_i (rd_addr_i),
        .stat_i    (state_q),
        .rd_data_o (rd_data_o)
    );

    // Next-state logic: software first, then hardware in rising priority.
    always_comb begin
        wr_hit    = wr_en_i && (wr_addr_i == CSR_ADDR);
        wdt_reset = wdt_timeout_i && state_q.pd;
        dev_reset = bor_rst_i || ext_rst_i || wdt_reset;
        state_d   = state_q;

        if (wr_hit) begin
            state_d.glintd = wr_data_i[B_GLINTD];
            state_d.por    = wr_data_i[B_POR];
            state_d.bor    = wr_data_i[B_BOR];
        end

        if (clrwdt_i) begin
            state_d.to = 1'b1;
            state_d.pd = 1'b1;
        end
        if (sleep_i) begin
            state_d.pd = 1'b0;
        end
        if (wdt_timeout_i) begin
            state_d.to = 1'b0;
        end
        if (stk_ovf) begin
            state_d.stkav = 1'b0;
        end

        if (dev_reset) begin
            state_d.stkav  = 1'b1;
            state_d.glintd = 1'b1;
        end
        if (bor_rst_i) begin
            state_d.to  = 1'b1;
            state_d.pd  = 1'b1;
            state_d.bor = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= STAT_POR;
        end else begin
            state_q <= state_d;
        end
    end

    assign glint_dis_o = state_q.glintd;

endmodule

// File: rtl/cpustat_chk.sv
module cpustat_chk
    import cpustat_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en_i,
    input logic [ADDR_W-1:0] wr_addr_i,
    input logic [DATA_W-1:0] rd_data_o,
    input logic              bor_rst_i,
    input logic              ext_rst_i,
    input logic              wdt_timeout_i,
    input logic              clrwdt_i,
    input logic              sleep_i,
    input logic              stk_push_i,
    input logic              glint_dis_o,
    input stat_t             stat
);
    logic hit;
    logic any_hw;
    assign hit    = wr_en_i && (wr_addr_i == CSR_ADDR);
    assign any_hw = bor_rst_i || ext_rst_i || wdt_timeout_i || clrwdt_i
                    || sleep_i || stk_push_i;

    // R2: unimplemented bits never read 1
    always_comb begin
        if (rst_n) begin
            p_hi_zero_r2: assert (rd_data_o[DATA_W-1:STAT_W] == '0);
        end
    end

    // R3: a clear stack flag stays clear without a device reset
    p_stkav_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!stat.stkav && !bor_rst_i && !ext_rst_i && !(wdt_timeout_i && stat.pd))
        |=> !stat.stkav);

    // R4: brown-out forces the interrupt disable output high
    p_bor_glint_r4: assert property (@(posedge clk) disable iff (!rst_n)
        bor_rst_i |=> glint_dis_o);

    // R5: a watchdog timeout clears the timeout flag unless brown-out wins
    p_wdt_to_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wdt_timeout_i && !bor_rst_i) |=> !stat.to);

    // R6: sleep clears the power-down flag unless brown-out wins
    p_sleep_pd_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (sleep_i && !bor_rst_i) |=> !stat.pd);

    // R7: external reset does not touch the power-on flag
    p_ext_por_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_rst_i && !hit) |=> $stable(stat.por));

    // R9: a plain write leaves hardware-owned bits alone
    p_ro_bits_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && !any_hw) |=> ($stable(stat.stkav) && $stable(stat.to) && $stable(stat.pd)));

endmodule

bind cpu_status_reg cpustat_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .wr_en_i       (wr_en_i),
    .wr_addr_i     (wr_addr_i),
    .rd_data_o     (rd_data_o),
    .bor_rst_i     (bor_rst_i),
    .ext_rst_i     (ext_rst_i),
    .wdt_timeout_i (wdt_timeout_i),
    .clrwdt_i      (clrwdt_i),
    .sleep_i       (sleep_i),
    .stk_push_i    (stk_push_i),
    .glint_dis_o   (glint_dis_o),
    .stat          (state_q)
);

// File: tb/tb_cpu_status_reg.sv
module tb_cpu_status_reg;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en_i = 1'b0;
    logic [7:0] wr_addr_i = 8'h00;
    logic [7:0] wr_data_i = 8'h00;
    logic [7:0] rd_addr_i = 8'h06;
    logic [7:0] rd_data_o;
    logic       bor_rst_i = 1'b0, ext_rst_i = 1'b0, wdt_timeout_i = 1'b0;
    logic       clrwdt_i = 1'b0, sleep_i = 1'b0, stk_push_i = 1'b0;
    logic [3:0] stk_ptr_i = 4'h0;
    logic       glint_dis_o;

    int n_chk = 0;
    int n_bad = 0;
    logic [5:0] exp_s;   // {stkav, glintd, to, pd, por, bor}

    always #2.5 clk = ~clk;

    cpu_status_reg dut (
        .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i),
        .wr_data_i(wr_data_i), .rd_addr_i(rd_addr_i), .rd_data_o(rd_data_o),
        .bor_rst_i(bor_rst_i), .ext_rst_i(ext_rst_i), .wdt_timeout_i(wdt_timeout_i),
        .clrwdt_i(clrwdt_i), .sleep_i(sleep_i), .stk_push_i(stk_push_i),
        .stk_ptr_i(stk_ptr_i), .glint_dis_o(glint_dis_o)
    );

    // Expected next state, written from the requirements.
    function automatic logic [5:0] model(input logic [5:0] s);
        logic [5:0] n = s;
        logic wrst;
        if (wr_en_i && wr_addr_i == 8'h06) begin
            n[4] = wr_data_i[4]; n[1] = wr_data_i[1]; n[0] = wr_data_i[0];
        end
        if (clrwdt_i) begin n[3] = 1'b1; n[2] = 1'b1; end
        if (sleep_i) n[2] = 1'b0;
        if (wdt_timeout_i) n[3] = 1'b0;
        if (stk_push_i && stk_ptr_i >= 4'hE) n[5] = 1'b0;
        wrst = wdt_timeout_i && s[2];
        if (bor_rst_i || ext_rst_i || wrst) begin n[5] = 1'b1; n[4] = 1'b1; end
        if (bor_rst_i) begin n[3] = 1'b1; n[2] = 1'b1; n[0] = 1'b0; end
        return n;
    endfunction

    function automatic logic [7:0] rd_img(input logic [5:0] s, input logic [7:0] a);
        return (a == 8'h06) ? {2'b00, s} : 8'h00;
    endfunction

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] expv);
        n_chk++;
        if (act !== expv) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, expv);
        end
    endtask

    task automatic idle();
        wr_en_i = 0; bor_rst_i = 0; ext_rst_i = 0; wdt_timeout_i = 0;
        clrwdt_i = 0; sleep_i = 0; stk_push_i = 0; rd_addr_i = 8'h06;
    endtask

    // Inputs set by caller at negedge; advance one edge and compare.
    task automatic step(input string tag);
        exp_s = model(exp_s);
        @(posedge clk); #1;
        check({tag, " rd"}, rd_data_o, rd_img(exp_s, rd_addr_i));
        check({tag, " glint"}, {7'd0, glint_dis_o}, {7'd0, exp_s[4]});
        @(negedge clk);
        idle();
    endtask

    task automatic wr(input logic [7:0] d);
        wr_en_i = 1; wr_addr_i = 8'h06; wr_data_i = d;
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        exp_s = 6'b111100;
        repeat (3) @(negedge clk);
        rst_n = 1;
        #1;
        check("R1 reset value", rd_data_o, 8'h3C);
        check("R1 R4 reset glint", {7'd0, glint_dis_o}, 8'h01);
        @(negedge clk);

        rd_addr_i = 8'h05; #1;
        check("R2 other address", rd_data_o, 8'h00);
        idle();

        wr(8'hFF); step("R9 R2 write ones");
        check("R2 R9 after FF", rd_data_o, 8'h3F);

        wr(8'h00); #1;
        check("R12 before edge", rd_data_o, 8'h3F);
        step("R9 R4 write zero");
        check("R9 after 00", rd_data_o, 8'h2C);

        sleep_i = 1; step("R6 sleep");
        check("R6 pd cleared", rd_data_o, 8'h28);
        wdt_timeout_i = 1; step("R11 wake");
        check("R11 R5 wake keeps rest", rd_data_o, 8'h20);
        clrwdt_i = 1; step("R5 R6 clrwdt");
        check("R5 R6 clrwdt sets", rd_data_o, 8'h2C);
        wdt_timeout_i = 1; step("R11 wdt reset");
        check("R11 R7 R8 wdt reset", rd_data_o, 8'h34);

        wr(8'h03); step("R7 R8 set flags");
        check("R7 R8 flags written", rd_data_o, 8'h27);
        ext_rst_i = 1; step("R7 R8 ext");
        check("R7 R8 ext keeps flags", rd_data_o, 8'h37);

        stk_push_i = 1; stk_ptr_i = 4'hD; step("R3 no ovf");
        check("R3 ptr D no clear", rd_data_o, 8'h37);
        stk_push_i = 1; stk_ptr_i = 4'hE; step("R3 ovf");
        check("R3 reach top clears", rd_data_o, 8'h17);
        wr(8'hFF); step("R3 sticky");
        check("R3 R9 write cannot set", rd_data_o, 8'h17);
        stk_push_i = 1; stk_ptr_i = 4'hF; step("R3 wrap");
        check("R3 wrap stays clear", rd_data_o, 8'h17);

        wr(8'h03); bor_rst_i = 1; step("R10 bor vs write");
        check("R10 R8 bor wins", rd_data_o, 8'h3E);
        wr(8'h00); ext_rst_i = 1; step("R10 ext vs write");
        check("R10 R4 ext wins glint", rd_data_o, 8'h3C);

        for (int i = 0; i < 2000; i++) begin
            wr_en_i       = ($urandom % 4) == 0;
            wr_addr_i     = (($urandom % 4) == 0) ? 8'($urandom) : 8'h06;
            wr_data_i     = 8'($urandom);
            rd_addr_i     = (($urandom % 8) == 0) ? 8'($urandom) : 8'h06;
            bor_rst_i     = ($urandom % 40) == 0;
            ext_rst_i     = ($urandom % 40) == 0;
            wdt_timeout_i = ($urandom % 16) == 0;
            clrwdt_i      = ($urandom % 10) == 0;
            sleep_i       = ($urandom % 10) == 0;
            stk_push_i    = ($urandom % 6) == 0;
            stk_ptr_i     = 4'($urandom);
            step("R12 random mix");
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule